// File: doc/BRIEF.md
# Register-File Byte ALU with Destination Steering

This block is the execute stage for byte-wide register operations in a small accumulator-style core. It contains a data memory of 128 eight-bit registers, a working accumulator and a zero flag. Each enabled clock it applies one of four operations to the register selected by a 7-bit address: clear the register, clear the accumulator, invert the register, or decrement the register.

The invert and decrement operations carry a destination bit. When that bit is 1, the result goes back into the addressed register. When it is 0, the result goes to the accumulator and the register is left as it was. Each operation reads the register, computes the result and writes it back within a single clock. The zero flag follows every result. The clear operations always leave the flag set.

A separate, independent read port lets the surrounding logic or a bench inspect any register without disturbing the operation in progress.

Top module: `fileop_unit`

## Requirements
- R1: While `rstN` is low, the accumulator, the zero flag and all 128 registers are cleared to 0.
- R2: Opcode 1 (clear register) writes 00h into the addressed register and sets the zero flag to 1. The accumulator is left unchanged.
- R3: Opcode 2 (clear accumulator) writes 00h into the accumulator and sets the zero flag to 1. No register is changed.
- R4: Opcode 3 (invert) with `destSel` = 1 stores the bitwise inverse of the addressed register back into that register. The accumulator is left unchanged.
- R5: Opcode 3 (invert) with `destSel` = 0 loads the bitwise inverse of the addressed register into the accumulator. The register is left unchanged.
- R6: Opcode 4 (decrement) stores the addressed register value minus one, modulo 256, so 00h becomes FFh. The result goes to the register when `destSel` = 1 and to the accumulator when `destSel` = 0; the location not chosen is left unchanged.
- R7: After an invert or decrement, the zero flag is 1 exactly when the 8-bit result is 00h.
- R8: When `enable` is low, or when the opcode is 0 (no operation) or any value from 5 to 7, the accumulator, the zero flag and every register keep their values.
- R9: An operation changes only the register at its own address. Every address from 0 to 127 holds its value independently.
- R10: Each operation takes one clock. Its result is visible on `wReg`, `zeroFlag` and `peekData` after the rising edge at which it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the presented operation to take effect |
| opCode | input | 3 | 0 none, 1 clear register, 2 clear accumulator, 3 invert, 4 decrement |
| regAddr | input | 7 | Address of the register being operated on |
| destSel | input | 1 | 1 = result to register, 0 = result to accumulator |
| peekAddr | input | 7 | Address for the inspection read port |
| wReg | output | 8 | Accumulator contents |
| zeroFlag | output | 1 | Zero flag |
| peekData | output | 8 | Contents of the register at `peekAddr` (combinational read) |

## Verification
The checker evaluates these properties on every cycle:
- The clear-accumulator result.
- The clear-register effect on the flag and the accumulator.
- The accumulator-destination results of invert and decrement, when the inspection port points at the operand.
- The flag rule for those results.
- The hold behaviour when `enable` is low.

The following depend on the bench's scenarios, which track a model of all 128 registers:
- Writes into the register file.
- The assurance that other addresses stay untouched.
- The wrap from 00h to FFh.
- The reset state of the whole memory.

// File: rtl/fileop_pkg.sv
package fileop_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CLRREG = 3'd1,
    OP_CLRACC = 3'd2,
    OP_INVERT = 3'd3,
    OP_DECR = 3'd4
  } fileOp_e;

  typedef enum logic [1:0] {
    RES_ZERO,
    RES_INV,
    RES_DEC
  } resKind_e;

  typedef struct packed {
    logic regWr;
    logic accWr;
    logic flagWr;
    resKind_e kind;
  } fileStrobe_t;
endpackage

// File: rtl/fileop_ctrl.sv
module fileop_ctrl
  import fileop_pkg::*;
(
  input logic enable,
  input logic [2:0] opCode,
  input logic destSel,
  output fileStrobe_t strobe
);
  always_comb begin
    strobe = '{regWr: 1'b0, accWr: 1'b0, flagWr: 1'b0, kind: RES_ZERO};
    if (enable) begin
      unique case (opCode)
        OP_CLRREG: begin
          strobe.regWr = 1'b1;
          strobe.flagWr = 1'b1;
          strobe.kind = RES_ZERO;
        end
        OP_CLRACC: begin
          strobe.accWr = 1'b1;
          strobe.flagWr = 1'b1;
          strobe.kind = RES_ZERO;
        end
        OP_INVERT: begin
          strobe.regWr = destSel;
          strobe.accWr = ~destSel;
          strobe.flagWr = 1'b1;
          strobe.kind = RES_INV;
        end
        OP_DECR: begin
          strobe.regWr = destSel;
          strobe.accWr = ~destSel;
          strobe.flagWr = 1'b1;
          strobe.kind = RES_DEC;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fileop_datapath.sv
module fileop_datapath
  import fileop_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input fileStrobe_t strobe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] wReg,
  output logic zeroFlag,
  output logic [DATA_W-1:0] peekData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regMem [DEPTH];
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] result;

  assign srcVal = regMem[regAddr];
  assign peekData = regMem[peekAddr];

  always_comb begin
    unique case (strobe.kind)
      RES_INV: result = ~srcVal;
      RES_DEC: result = srcVal - DATA_W'(1);
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regMem[i] <= '0;
    end else if (strobe.regWr) begin
      regMem[regAddr] <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg <= '0;
      zeroFlag <= 1'b0;
    end else begin
      if (strobe.accWr) wReg <= result;
      if (strobe.flagWr) zeroFlag <= (result == '0);
    end
  end
endmodule

// File: rtl/fileop_unit.sv
module fileop_unit
  import fileop_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic [2:0] opCode,
  input logic [ADDR_W-1:0] regAddr,
  input logic destSel,
  input logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] wReg,
  output logic zeroFlag,
  output logic [DATA_W-1:0] peekData
);
  fileStrobe_t strobe;

  fileop_ctrl u_ctrl (
    .enable(enable),
    .opCode(opCode),
    .destSel(destSel),
    .strobe(strobe)
  );

  fileop_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .regAddr(regAddr),
    .peekAddr(peekAddr),
    .wReg(wReg),
    .zeroFlag(zeroFlag),
    .peekData(peekData)
  );
endmodule

// File: rtl/fileop_chk.sv
module fileop_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic [2:0] opCode,
  input logic [ADDR_W-1:0] regAddr,
  input logic destSel,
  input logic [ADDR_W-1:0] peekAddr,
  input logic [DATA_W-1:0] wReg,
  input logic zeroFlag,
  input logic [DATA_W-1:0] peekData
);
  logic samePeek;
  assign samePeek = (peekAddr == regAddr);

  p_clracc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && opCode == 3'd2) |=> (wReg == '0 && zeroFlag));

  p_clrreg_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && opCode == 3'd1) |=> (zeroFlag && wReg == $past(wReg)));

  p_inv_reg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && opCode == 3'd3 && destSel) |=> (wReg == $past(wReg)));

  p_inv_acc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && opCode == 3'd3 && !destSel && samePeek) |=> (wReg == ~$past(peekData)));

  p_dec_acc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && opCode == 3'd4 && !destSel && samePeek) |=> (wReg == $past(peekData) - 8'd1));

  p_flag_acc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (opCode == 3'd3 || opCode == 3'd4) && !destSel) |=> (zeroFlag == (wReg == '0)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> ($stable(wReg) && $stable(zeroFlag)));
endmodule

bind fileop_unit fileop_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fileop_unit_tb.sv
module fileop_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [6:0] regAddr = 7'd0;
  logic destSel = 1'b0;
  logic [6:0] peekAddr = 7'd0;
  logic [7:0] wReg;
  logic zeroFlag;
  logic [7:0] peekData;

  int checks = 0;
  int fails = 0;
  logic [7:0] refMem [128];
  logic [7:0] refW;
  logic refZ;

  always #4 clk = ~clk;

  fileop_unit u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] calcResult(logic [2:0] op, logic [7:0] src);
    case (op)
      3'd3: return ~src;
      3'd4: return src - 8'd1;
      default: return 8'd0;
    endcase
  endfunction

  function automatic string tagFor(logic en, logic [2:0] op, logic d);
    if (!en || op == 3'd0 || op > 3'd4) return "R8";
    if (op == 3'd1) return "R2";
    if (op == 3'd2) return "R3";
    if (op == 3'd3) return d ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic modelStep(logic en, logic [2:0] op, logic [6:0] a, logic d);
    logic [7:0] res;
    res = calcResult(op, refMem[a]);
    if (en) begin
      case (op)
        3'd1: begin refMem[a] = 8'd0; refZ = 1'b1; end
        3'd2: begin refW = 8'd0; refZ = 1'b1; end
        3'd3, 3'd4: begin
          if (d) refMem[a] = res; else refW = res;
          refZ = (res == 8'd0);
        end
        default: ;
      endcase
    end
  endtask

  // drive at negedge, compare at following negedge (one clock, R10)
  task automatic doOp(logic en, logic [2:0] op, logic [6:0] a, logic d, logic [6:0] other);
    string tag;
    tag = tagFor(en, op, d);
    @(negedge clk);
    enable = en; opCode = op; regAddr = a; destSel = d; peekAddr = a;
    modelStep(en, op, a, d);
    @(negedge clk);
    enable = 1'b0;
    #1;
    check({tag, " R10 acc"}, wReg, refW);
    check({tag, " R7 flag"}, {7'd0, zeroFlag}, {7'd0, refZ});
    check({tag, " reg"}, peekData, refMem[a]);
    peekAddr = other;
    #1;
    check("R9 other", peekData, refMem[other]);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 128; i++) refMem[i] = 8'd0;
    refW = 8'd0;
    refZ = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: whole memory and state after reset
    check("R1 acc", wReg, 8'd0);
    check("R1 flag", {7'd0, zeroFlag}, 8'd0);
    for (int i = 0; i < 128; i++) begin
      peekAddr = 7'(i);
      #1;
      check("R1 mem", peekData, 8'd0);
    end
    // directed corners
    doOp(1'b1, 3'd4, 7'd5, 1'b1, 7'd6);    // R6 wrap 00 -> FF
    check("R6 wrap", refMem[5], 8'hFF);
    doOp(1'b1, 3'd4, 7'd5, 1'b0, 7'd4);    // R6 to acc: FE, reg keeps FF
    doOp(1'b1, 3'd3, 7'd5, 1'b0, 7'd0);    // R5 ~FF = 00, Z set (R7)
    doOp(1'b1, 3'd3, 7'd127, 1'b1, 7'd126); // R4 top address
    doOp(1'b0, 3'd1, 7'd127, 1'b1, 7'd5);  // R8 disabled clear
    doOp(1'b1, 3'd0, 7'd127, 1'b1, 7'd5);  // R8 no-op code
    doOp(1'b1, 3'd7, 7'd127, 1'b1, 7'd5);  // R8 unused code
    doOp(1'b1, 3'd1, 7'd127, 1'b0, 7'd5);  // R2
    doOp(1'b1, 3'd4, 7'd0, 1'b0, 7'd1);    // R6 acc FF
    doOp(1'b1, 3'd2, 7'd0, 1'b0, 7'd5);    // R3
    doOp(1'b1, 3'd3, 7'd9, 1'b1, 7'd10);
    doOp(1'b1, 3'd4, 7'd9, 1'b1, 7'd10);   // FF-1 = FE
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] op;
      logic en;
      en = ($urandom % 8) != 0;
      op = 3'($urandom % 6);
      if (($urandom % 10) == 0) op = 3'($urandom);
      doOp(en, op, 7'($urandom % 16), 1'($urandom), 7'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule